// File: doc/BRIEF.md
# Byte-Addressed Register Adder

This block is a small sequential datapath built around a 32-bit adder. Two 32-bit operand registers are filled one byte at a time through an 8-bit input port. A compute strobe captures their sum into a 32-bit result register and a one-bit carry register. The result and the carry are then read back one byte at a time through an 8-bit output port.

A single address decoder serves both directions. On a write it steers the input byte into one byte lane of one operand register. On a read it picks which result byte, or the carry, drives the output port. The address map is fixed by the decode, so a host needs only an address, a byte, and two strobes to drive a full 32-bit addition.

Top module: `byte_reg_adder`

## Requirements
- R1: With `wr_en` high at a rising edge and `addr` in 0..3, byte lane `addr` of operand A (lane 0 = bits 7:0) takes `din`; the other A lanes are unchanged.
- R2: With `wr_en` high at a rising edge and `addr` in 4..7, byte lane `addr-4` of operand B (lane 0 = bits 7:0) takes `din`; the other B lanes are unchanged.
- R3: A write with `addr` in 8..15 changes neither operand register.
- R4: When `wr_en` is low, both operand registers hold their value.
- R5: When `cmp_en` is high at a rising edge, that edge loads the result register with bits 31:0 and the carry register with bit 32 of the 33-bit sum A+B. The operands used are the values held before that edge, so a write in the same cycle is not yet included.
- R6: When `cmp_en` is low, the result and carry registers hold their value.
- R7: Addresses 8..11 read result byte `addr-8` (lane 0 = bits 7:0) on `dout`.
- R8: Address 12 reads the carry in `dout` bit 0, with bits 7:1 zero.
- R9: Addresses 0..7 and 13..15 read as zero.
- R10: `dout` depends only on `addr` and the registered state. It follows a change of `addr` within the same cycle, with no clock edge.
- R11: `rst` high at a rising edge clears both operands, the result and the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the operand byte at `addr` |
| cmp_en | input | 1 | Compute strobe; loads result and carry |
| addr | input | 4 | Shared byte address for write and readback |
| din | input | 8 | Input byte |
| dout | output | 8 | Readback byte selected by `addr` |

## Verification
The assertions assume that `wr_en`, `cmp_en`, `addr` and `din` are stable around each rising edge. They also assume that `addr` is a known value whenever the block is out of reset. The stimulus meets both conditions by driving every input on the falling edge, and by parking `addr` at zero with both strobes low between operations. Random `addr` values cover all sixteen codes, so writes to the result, carry and unused codes are exercised. Directed cases add a full carry-out, a write and a compute in the same cycle, and an address change that is read within one cycle.

// File: rtl/bra_pkg.sv
package bra_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned OPER_W     = 32;
    localparam int unsigned LANE_N     = OPER_W / BYTE_W;
    localparam int unsigned LANE_IDX_W = (LANE_N > 1) ? $clog2(LANE_N) : 1;
    localparam int unsigned SEL_W      = 4;

    // address space a decoded byte address falls into
    typedef enum logic [2:0] {
        SP_OPA   = 3'd0,
        SP_OPB   = 3'd1,
        SP_SUM   = 3'd2,
        SP_CARRY = 3'd3,
        SP_VOID  = 3'd4
    } space_e;

    typedef struct packed {
        space_e                space;
        logic [LANE_IDX_W-1:0] lane;
    } loc_t;

    typedef struct packed {
        logic              carry;
        logic [OPER_W-1:0] sum;
    } result_t;

    // blocks of LANE_N addresses: A, B, result, then carry at the first slot
    function automatic loc_t map_addr(input logic [SEL_W-1:0] a);
        loc_t        l;
        int unsigned blk;
        blk    = 32'(a) / LANE_N;
        l.lane = LANE_IDX_W'(32'(a) % LANE_N);
        case (blk)
            0:       l.space = SP_OPA;
            1:       l.space = SP_OPB;
            2:       l.space = SP_SUM;
            3:       l.space = (l.lane == '0) ? SP_CARRY : SP_VOID;
            default: l.space = SP_VOID;
        endcase
        return l;
    endfunction

    function automatic logic [LANE_N-1:0] lane_onehot(input logic [LANE_IDX_W-1:0] lane);
        return LANE_N'(1) << lane;
    endfunction

    function automatic logic [BYTE_W-1:0] byte_of(input logic [OPER_W-1:0] w,
                                                  input logic [LANE_IDX_W-1:0] lane);
        return BYTE_W'(w >> (32'(lane) * BYTE_W));
    endfunction

endpackage

// File: rtl/bra_decode.sv
module bra_decode
    import bra_pkg::*;
(
    input  logic [SEL_W-1:0]  addr,
    input  logic              wr_en,
    output loc_t              rd_loc,
    output logic [LANE_N-1:0] we_a,
    output logic [LANE_N-1:0] we_b
);

    loc_t loc;

    always_comb begin
        loc    = map_addr(addr);
        rd_loc = loc;
        we_a   = '0;
        we_b   = '0;
        if (wr_en) begin
            if (loc.space == SP_OPA) we_a = lane_onehot(loc.lane);
            if (loc.space == SP_OPB) we_b = lane_onehot(loc.lane);
        end
    end

endmodule

// File: rtl/bra_lane_reg.sv
module bra_lane_reg
    import bra_pkg::*;
#(
    parameter int unsigned LANES = LANE_N,
    parameter int unsigned BW    = BYTE_W,
    localparam int unsigned W    = LANES * BW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] we,
    input  logic [BW-1:0]    din,
    output logic [W-1:0]     q
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)        q[g*BW +: BW] <= '0;
            else if (we[g]) q[g*BW +: BW] <= din;
        end
    end

endmodule

// File: rtl/bra_sum_unit.sv
module bra_sum_unit
    import bra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_en,
    input  logic [OPER_W-1:0] opa,
    input  logic [OPER_W-1:0] opb,
    output result_t           res_q
);

    result_t res_d;

    always_comb begin
        res_d = {1'b0, opa} + {1'b0, opb};
    end

    always_ff @(posedge clk) begin
        if (rst)         res_q <= '0;
        else if (cmp_en) res_q <= res_d;
    end

endmodule

// File: rtl/bra_read_mux.sv
module bra_read_mux
    import bra_pkg::*;
(
    input  loc_t              loc,
    input  result_t           res,
    output logic [BYTE_W-1:0] dout
);

    always_comb begin
        case (loc.space)
            SP_SUM:   dout = byte_of(res.sum, loc.lane);
            SP_CARRY: dout = {{(BYTE_W-1){1'b0}}, res.carry};
            default:  dout = '0;
        endcase
    end

endmodule

// File: rtl/byte_reg_adder.sv
module byte_reg_adder
    import bra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              cmp_en,
    input  logic [SEL_W-1:0]  addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    loc_t              rd_loc;
    logic [LANE_N-1:0] we_a;
    logic [LANE_N-1:0] we_b;
    logic [OPER_W-1:0] opa_q;
    logic [OPER_W-1:0] opb_q;
    result_t           res_q;

    bra_decode u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_loc (rd_loc),
        .we_a   (we_a),
        .we_b   (we_b)
    );

    bra_lane_reg u_opa (
        .clk (clk),
        .rst (rst),
        .we  (we_a),
        .din (din),
        .q   (opa_q)
    );

    bra_lane_reg u_opb (
        .clk (clk),
        .rst (rst),
        .we  (we_b),
        .din (din),
        .q   (opb_q)
    );

    bra_sum_unit u_sum (
        .clk    (clk),
        .rst    (rst),
        .cmp_en (cmp_en),
        .opa    (opa_q),
        .opb    (opb_q),
        .res_q  (res_q)
    );

    bra_read_mux u_rd (
        .loc  (rd_loc),
        .res  (res_q),
        .dout (dout)
    );

endmodule

// File: rtl/byte_reg_adder_chk.sv
module byte_reg_adder_chk
    import bra_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              cmp_en,
    input logic [SEL_W-1:0]  addr,
    input logic [BYTE_W-1:0] din,
    input logic [BYTE_W-1:0] dout,
    input logic [OPER_W-1:0] opa_q,
    input logic [OPER_W-1:0] opb_q,
    input logic [OPER_W-1:0] res_sum,
    input logic              res_carry
);

    localparam logic [SEL_W-1:0] B_BASE = SEL_W'(LANE_N);
    localparam logic [SEL_W-1:0] R_BASE = SEL_W'(2 * LANE_N);
    localparam logic [SEL_W-1:0] C_ADDR = SEL_W'(3 * LANE_N);

    // R1
    a_lane_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr < B_BASE) |=>
        byte_of(opa_q, $past(addr[LANE_IDX_W-1:0])) == $past(din));

    // R2
    b_lane_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= B_BASE && addr < R_BASE) |=>
        byte_of(opb_q, $past(addr[LANE_IDX_W-1:0])) == $past(din));

    // R3
    high_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= R_BASE) |=> ($stable(opa_q) && $stable(opb_q)));

    // R4
    operands_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(opa_q) && $stable(opb_q)));

    // R5
    sum_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_en |=> {res_carry, res_sum} == ({1'b0, $past(opa_q)} + {1'b0, $past(opb_q)}));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_en |=> ($stable(res_sum) && $stable(res_carry)));

    // R8
    carry_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == C_ADDR) |-> (dout == {{(BYTE_W-1){1'b0}}, res_carry}));

    // R9
    void_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr < R_BASE || addr > C_ADDR) |-> (dout == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (opa_q == '0 && opb_q == '0 && res_sum == '0 && !res_carry));

endmodule

bind byte_reg_adder byte_reg_adder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .cmp_en    (cmp_en),
    .addr      (addr),
    .din       (din),
    .dout      (dout),
    .opa_q     (opa_q),
    .opb_q     (opb_q),
    .res_sum   (res_q.sum),
    .res_carry (res_q.carry)
);

// File: tb/tb_byte_reg_adder.sv
module tb_byte_reg_adder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       cmp_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] din = 8'd0;
    logic [7:0] dout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_a = '0;
    logic [31:0] m_b = '0;
    logic [32:0] m_r = '0;

    always #10 clk = ~clk;

    byte_reg_adder dut (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .cmp_en (cmp_en),
        .addr   (addr),
        .din    (din),
        .dout   (dout)
    );

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a >= 4'd8 && a <= 4'd11) return 8'(m_r[31:0] >> (8 * (int'(a) - 8)));
        if (a == 4'd12) return {7'd0, m_r[32]};
        return 8'd0;
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        if (a >= 4'd8 && a <= 4'd11) return "R7";
        if (a == 4'd12) return "R8";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // sets inputs at a falling edge, applies one rising edge, updates the model
    task automatic cycle(input bit we, input bit cmp, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = we; cmp_en = cmp; addr = a; din = d;
        @(posedge clk);
        #2;
        if (cmp) m_r = {1'b0, m_a} + {1'b0, m_b};
        if (we && a < 4'd4) m_a[8*a +: 8] = d;
        if (we && a >= 4'd4 && a < 4'd8) m_b[8*(a-4) +: 8] = d;
        wr_en = 1'b0; cmp_en = 1'b0; addr = 4'd0;
    endtask

    task automatic read_chk(input logic [3:0] a, input string tag);
        addr = a;
        #1;
        check(tag, dout, exp_read(a));
    endtask

    task automatic read_result(input string tag);
        for (int k = 8; k <= 12; k++) read_chk(4'(k), tag);
    endtask

    task automatic load_word(input bit is_b, input logic [31:0] w);
        for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, 4'(k + (is_b ? 4 : 0)), w[8*k +: 8]);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R11: reset state, every address reads zero
        for (int k = 0; k < 16; k++) read_chk(4'(k), "R11");

        // R1 R2 R5 R7: directed words
        load_word(1'b0, 32'h1234_5678);
        load_word(1'b1, 32'h0FED_CBA9);
        cycle(1'b0, 1'b1, 4'd0, 8'd0);
        read_result("R5");

        // R8: full carry out, sum wraps to zero
        load_word(1'b0, 32'hFFFF_FFFF);
        load_word(1'b1, 32'h0000_0001);
        cycle(1'b0, 1'b1, 4'd0, 8'd0);
        read_result("R8");

        // R3: writes to result/carry/unused codes leave operands alone
        for (int k = 8; k < 16; k++) cycle(1'b1, 1'b0, 4'(k), 8'hA5);
        read_result("R6");
        cycle(1'b0, 1'b1, 4'd0, 8'd0);
        read_result("R3");

        // R4: partial lane update keeps other lanes
        cycle(1'b1, 1'b0, 4'd6, 8'h80);
        cycle(1'b0, 1'b1, 4'd0, 8'd0);
        read_result("R4");

        // R5: write and compute in one cycle uses the old operand
        cycle(1'b1, 1'b1, 4'd1, 8'h77);
        read_result("R5");
        cycle(1'b0, 1'b1, 4'd0, 8'd0);
        read_result("R1");

        // R10: address changes within one cycle
        @(negedge clk);
        read_chk(4'd8, "R10");
        read_chk(4'd12, "R10");
        read_chk(4'd11, "R10");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            bit we, cmp;
            a   = 4'($urandom_range(0, 15));
            we  = ($urandom_range(0, 3) != 0);
            cmp = ($urandom_range(0, 4) == 0);
            cycle(we, cmp, a, 8'($urandom));
            a = 4'($urandom_range(0, 15));
            read_chk(a, tag_of(a));
            if (cmp) read_result("R2");
        end

        // R11: reset mid-operation clears result and carry
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
        m_a = '0; m_b = '0; m_r = '0;
        read_result("R11");
        cycle(1'b0, 1'b1, 4'd0, 8'd0);
        read_result("R11");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule